// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block keeps the programmable transfer state of four DMA channels. Each channel has a 16-bit base address, a 16-bit base count, and a pair of working counters, the current address and the current count. Software reaches all of it through one 8-bit register port. A single byte pointer, shared by every channel, decides whether an access touches the low or the high byte, and it flips after each channel access. A 16-bit value is therefore written or read as two successive bytes, low byte first.

Writing the high byte of either register of a channel restarts that channel. Its current address takes the base address scaled by the controller width, and its current count returns to zero. An external transfer engine reports progress by writing a new current count through a separate update input. Reads do not return the stored bases directly. The address read gives the current address moved forward by the progress (or backward when that channel counts down). The count read gives the scaled base count less the progress. A shift parameter selects a byte-wide controller (0) or a word-wide controller (1). It sets both the port address decode and the scaling of the values.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the byte pointer is 0, every base and current register is zero, and every channel read returns 0.
- R2: The register index is bits 3:0 of `reg_addr >> SHIFT`. Index bits 3:1 select the channel and index bit 0 selects the address (0) or count (1) register. An access whose index is 8 or more is ignored: the pointer does not move, read data is 0, and no register changes.
- R3: Every read or write at an index below 8 inverts the one byte pointer shared by all channels, on the clock edge of the access.
- R4: `ptr_clr` makes the byte pointer 0 at the next edge with no toggle, even when an access occurs in the same cycle. That access still uses the pointer value it found.
- R5: A write with pointer 0 replaces bits 7:0 of the selected base register. A write with pointer 1 replaces bits 15:8.
- R6: A pointer-1 write to either register of a channel loads that channel's current address with the base address shifted left by SHIFT, using the byte just written if it was the address register, and clears its current count. A pointer-0 write leaves both current values unchanged.
- R7: Count read value = (base count << SHIFT) − current count, modulo 2^(16+SHIFT).
- R8: Address read value = current address + current count, or current address − current count when the channel's `mode_dec` bit is 1, modulo 2^(16+SHIFT).
- R9: The read byte is bits SHIFT+7:SHIFT of the value when the pointer is 0, and bits SHIFT+15:SHIFT+8 when it is 1. It appears combinationally in the cycle `reg_rd` is high, and `reg_rdata` is 0 when no read is made.
- R10: `upd_valid` loads `upd_count` into the current count of channel `upd_chan` at the next edge. If a pointer-1 write reloads that same channel in the same cycle, the reload wins and the count becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | PORT_W | Register port address |
| reg_wr | input | 1 | Write strobe, one access per cycle high |
| reg_rd | input | 1 | Read strobe, one access per cycle high |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte, valid while reg_rd is high |
| ptr_clr | input | 1 | Clears the byte pointer |
| mode_dec | input | NUM_CH | Per-channel count-down flag for address reads |
| upd_valid | input | 1 | Current-count update strobe |
| upd_chan | input | CH_W | Channel that receives the update |
| upd_count | input | 16+SHIFT | New current count |
| byte_ptr | output | 1 | Present byte pointer |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle. They also assume that `upd_chan` names an existing channel. The stimulus makes exactly one register access per task call and keeps the update channel in range. Under these assumptions each pointer step corresponds to exactly one access. Both a byte-wide and a word-wide instance receive the same indices, so each read checks the decode and the value scaling for both shift settings.

// File: rtl/dma_chan_regs_pkg.sv
package dma_chan_regs_pkg;

  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_CNT  = 1'b1
  } reg_sel_e;

  // position-independent readback arithmetic on 32-bit working values
  function automatic logic [31:0] addr_readback(input logic [31:0] cur_a,
                                                input logic [31:0] cur_c,
                                                input logic        dec);
    return dec ? (cur_a - cur_c) : (cur_a + cur_c);
  endfunction

  function automatic logic [31:0] count_readback(input logic [15:0]   base_c,
                                                 input int unsigned   sh,
                                                 input logic [31:0]   cur_c);
    return (32'(base_c) << sh) - cur_c;
  endfunction

  function automatic logic [7:0] byte_of(input logic [31:0] v,
                                         input int unsigned sh,
                                         input logic        p);
    return 8'(v >> (sh + (p ? 32'd8 : 32'd0)));
  endfunction

endpackage

// File: rtl/dma_chan_regs_decode.sv
module dma_chan_regs_decode
  import dma_chan_regs_pkg::*;
#(
  parameter int SHIFT  = 0,
  parameter int PORT_W = 8,
  parameter int NUM_CH = 4
) (
  input  logic [PORT_W-1:0] port_addr,
  input  logic              wr,
  input  logic              rd,
  output logic              acc,
  output logic              miss,
  output logic [2:0]        chan,
  output reg_sel_e          sel
);
  localparam int IDX_LIMIT = 2 * NUM_CH;

  logic [3:0] idx;
  logic       in_range;

  assign idx      = 4'(port_addr >> SHIFT);
  assign in_range = (32'(idx) < 32'(IDX_LIMIT));
  assign acc      = (wr | rd) & in_range;
  assign miss     = (wr | rd) & ~in_range;
  assign chan     = idx[3:1];
  assign sel      = reg_sel_e'(idx[0]);
endmodule

// File: rtl/dma_chan_regs_byteptr.sv
module dma_chan_regs_byteptr (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= 1'b0;
    else if (clr)  ptr <= 1'b0;
    else if (step) ptr <= ~ptr;
  end
endmodule

// File: rtl/dma_chan_regs_channel.sv
module dma_chan_regs_channel
  import dma_chan_regs_pkg::*;
#(
  parameter int SHIFT = 0,
  parameter int CUR_W = 16 + SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  reg_sel_e         sel,
  input  logic             ptr,
  input  logic [7:0]       wdata,
  input  logic             upd_en,
  input  logic [CUR_W-1:0] upd_val,
  output logic [15:0]      base_c,
  output logic [CUR_W-1:0] cur_a,
  output logic [CUR_W-1:0] cur_c,
  output logic             reload
);
  logic [15:0]      base_a;
  logic [15:0]      nxt_base_a;
  logic [15:0]      nxt_base_c;
  logic             wr_a;
  logic             wr_c;
  logic [CUR_W-1:0] reload_addr;

  assign wr_a   = hit && (sel == SEL_ADDR);
  assign wr_c   = hit && (sel == SEL_CNT);
  assign reload = hit && ptr;

  always_comb begin
    nxt_base_a = base_a;
    nxt_base_c = base_c;
    if (wr_a) begin
      if (ptr) nxt_base_a = {wdata, base_a[7:0]};
      else     nxt_base_a = {base_a[15:8], wdata};
    end
    if (wr_c) begin
      if (ptr) nxt_base_c = {wdata, base_c[7:0]};
      else     nxt_base_c = {base_c[15:8], wdata};
    end
  end

  assign reload_addr = CUR_W'(nxt_base_a) << SHIFT;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_a <= '0;
      base_c <= '0;
      cur_a  <= '0;
      cur_c  <= '0;
    end else begin
      base_a <= nxt_base_a;
      base_c <= nxt_base_c;
      if (reload) begin
        cur_a <= reload_addr;
        cur_c <= '0;
      end else if (upd_en) begin
        cur_c <= upd_val;
      end
    end
  end
endmodule

// File: rtl/dma_chan_regs_readback.sv
module dma_chan_regs_readback
  import dma_chan_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SHIFT  = 0,
  parameter int CUR_W  = 16 + SHIFT,
  parameter int CH_W   = 2
) (
  input  logic             rd_en,
  input  logic [CH_W-1:0]  ch,
  input  reg_sel_e         sel,
  input  logic             ptr,
  input  logic [NUM_CH-1:0] dec,
  input  logic [15:0]      base_c [NUM_CH],
  input  logic [CUR_W-1:0] cur_a  [NUM_CH],
  input  logic [CUR_W-1:0] cur_c  [NUM_CH],
  output logic [7:0]       rdata
);
  logic [31:0] val_a;
  logic [31:0] val_c;
  logic [31:0] val;

  always_comb begin
    val_a = addr_readback(32'(cur_a[ch]), 32'(cur_c[ch]), dec[ch]);
    val_c = count_readback(base_c[ch], SHIFT, 32'(cur_c[ch]));
    val   = (sel == SEL_CNT) ? val_c : val_a;
    rdata = rd_en ? byte_of(val, SHIFT, ptr) : 8'h00;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_regs_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int SHIFT  = 0,
  parameter int PORT_W = 8,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int CUR_W  = 16 + SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              ptr_clr,
  input  logic [NUM_CH-1:0] mode_dec,
  input  logic              upd_valid,
  input  logic [CH_W-1:0]   upd_chan,
  input  logic [CUR_W-1:0]  upd_count,
  output logic              byte_ptr
);
  logic             acc;
  logic             miss;
  logic [2:0]       chan;
  reg_sel_e         sel;
  logic             rd_en;
  logic [NUM_CH-1:0] reload_vec;
  logic [15:0]      base_cnt_q [NUM_CH];
  logic [CUR_W-1:0] cur_addr_q [NUM_CH];
  logic [CUR_W-1:0] cur_cnt_q  [NUM_CH];

  dma_chan_regs_decode #(
    .SHIFT (SHIFT),
    .PORT_W(PORT_W),
    .NUM_CH(NUM_CH)
  ) u_decode (
    .port_addr(reg_addr),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .acc      (acc),
    .miss     (miss),
    .chan     (chan),
    .sel      (sel)
  );

  dma_chan_regs_byteptr u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (ptr_clr),
    .step (acc),
    .ptr  (byte_ptr)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit_i;
    logic upd_i;
    assign hit_i = reg_wr && acc && (chan == 3'(i));
    assign upd_i = upd_valid && (upd_chan == CH_W'(i));

    dma_chan_regs_channel #(
      .SHIFT(SHIFT),
      .CUR_W(CUR_W)
    ) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (hit_i),
      .sel    (sel),
      .ptr    (byte_ptr),
      .wdata  (reg_wdata),
      .upd_en (upd_i),
      .upd_val(upd_count),
      .base_c (base_cnt_q[i]),
      .cur_a  (cur_addr_q[i]),
      .cur_c  (cur_cnt_q[i]),
      .reload (reload_vec[i])
    );
  end

  assign rd_en = reg_rd && acc;

  dma_chan_regs_readback #(
    .NUM_CH(NUM_CH),
    .SHIFT (SHIFT),
    .CUR_W (CUR_W),
    .CH_W  (CH_W)
  ) u_rb (
    .rd_en (rd_en),
    .ch    (CH_W'(chan)),
    .sel   (sel),
    .ptr   (byte_ptr),
    .dec   (mode_dec),
    .base_c(base_cnt_q),
    .cur_a (cur_addr_q),
    .cur_c (cur_cnt_q),
    .rdata (reg_rdata)
  );
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int NUM_CH = 4,
  parameter int CUR_W  = 16,
  parameter int CH_W   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc,
  input logic              miss,
  input logic              ptr_clr,
  input logic              byte_ptr,
  input logic              reg_rd,
  input logic [7:0]        reg_rdata,
  input logic              upd_valid,
  input logic [CH_W-1:0]   upd_chan,
  input logic [CUR_W-1:0]  upd_count,
  input logic [NUM_CH-1:0] reload_vec,
  input logic [CUR_W-1:0]  cur_cnt_q [NUM_CH]
);
  a_r3_access_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !ptr_clr |=> byte_ptr != $past(byte_ptr));

  a_r4_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_clr |=> !byte_ptr);

  a_r2_miss_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    !acc && !ptr_clr |=> $stable(byte_ptr));

  a_r2_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    miss && reg_rd |-> reg_rdata == 8'h00);

  a_r6_single_reload: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reload_vec));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    a_r6_reload_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      reload_vec[c] |=> cur_cnt_q[c] == '0);

    a_r10_update_loads: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid && (upd_chan == CH_W'(c)) && !reload_vec[c]
      |=> cur_cnt_q[c] == $past(upd_count));
  end
endmodule

bind dma_chan_regs dma_chan_regs_chk #(
  .NUM_CH(NUM_CH),
  .CUR_W (CUR_W),
  .CH_W  (CH_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc       (acc),
  .miss      (miss),
  .ptr_clr   (ptr_clr),
  .byte_ptr  (byte_ptr),
  .reg_rd    (reg_rd),
  .reg_rdata (reg_rdata),
  .upd_valid (upd_valid),
  .upd_chan  (upd_chan),
  .upd_count (upd_count),
  .reload_vec(reload_vec),
  .cur_cnt_q (cur_cnt_q)
);

// File: tb/dma_chan_regs_tb.sv
module dma_chan_regs_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0]  idx;
  logic        wr, rd, clr, upd;
  logic [7:0]  wdata;
  logic [3:0]  dec;
  logic [1:0]  uch;
  logic [16:0] uval;
  logic [7:0]  rdata0, rdata1;
  logic        ptr0, ptr1;

  dma_chan_regs #(.SHIFT(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr({4'b0, idx}), .reg_wr(wr), .reg_rd(rd),
    .reg_wdata(wdata), .reg_rdata(rdata0), .ptr_clr(clr), .mode_dec(dec),
    .upd_valid(upd), .upd_chan(uch), .upd_count(uval[15:0]), .byte_ptr(ptr0));

  dma_chan_regs #(.SHIFT(1)) u_dut_w (
    .clk(clk), .rst_n(rst_n), .reg_addr({3'b0, idx, 1'b0}), .reg_wr(wr), .reg_rd(rd),
    .reg_wdata(wdata), .reg_rdata(rdata1), .ptr_clr(clr), .mode_dec(dec),
    .upd_valid(upd), .upd_chan(uch), .upd_count(uval), .byte_ptr(ptr1));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  int mba[4], mbc[4];
  int mca[2][4], mcc[2][4];
  bit mptr;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_byte(int s, int i, bit p);
    int ch, modv, v;
    if (i >= 8) return 0;
    ch = i / 2;
    modv = 1 << (16 + s);
    if (i % 2 == 1) v = mbc[ch] * (1 << s) - mcc[s][ch];
    else if (dec[ch]) v = mca[s][ch] - mcc[s][ch];
    else v = mca[s][ch] + mcc[s][ch];
    v = ((v % modv) + modv) % modv;
    return (v / (1 << (s + 8 * int'(p)))) % 256;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 4; c++) begin
      mba[c] = 0; mbc[c] = 0;
      for (int s = 0; s < 2; s++) begin mca[s][c] = 0; mcc[s][c] = 0; end
    end
    mptr = 0;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    wr = 0; rd = 0; clr = 0; upd = 0;
  endtask

  task automatic do_write(int i, int d, bit c = 0, bit u = 0, int uc = 0, int uv = 0);
    int ch;
    @(negedge clk);
    idx = 4'(i); wdata = 8'(d); wr = 1; clr = c; upd = u; uch = 2'(uc); uval = 17'(uv);
    idle();
    if (u) for (int s = 0; s < 2; s++) mcc[s][uc] = uv % (1 << (16 + s));
    if (i < 8) begin
      ch = i / 2;
      if (i % 2 == 0) mba[ch] = mptr ? (mba[ch] % 256) + d * 256 : (mba[ch] / 256) * 256 + d;
      else            mbc[ch] = mptr ? (mbc[ch] % 256) + d * 256 : (mbc[ch] / 256) * 256 + d;
      if (mptr) for (int s = 0; s < 2; s++) begin
        mca[s][ch] = mba[ch] * (1 << s);
        mcc[s][ch] = 0;
      end
      mptr = !mptr;
    end
    if (c) mptr = 0;
  endtask

  task automatic do_read(string req, int i, int exp = -1, bit c = 0);
    @(negedge clk);
    idx = 4'(i); rd = 1; clr = c;
    #2;
    check(req, int'(rdata0), (exp < 0) ? exp_byte(0, i, mptr) : exp);
    check(req, int'(rdata1), (exp < 0) ? exp_byte(1, i, mptr) : exp);
    idle();
    if (i < 8) mptr = !mptr;
    if (c) mptr = 0;
  endtask

  task automatic do_upd(int ch, int v);
    @(negedge clk);
    upd = 1; uch = 2'(ch); uval = 17'(v);
    idle();
    for (int s = 0; s < 2; s++) mcc[s][ch] = v;
  endtask

  task automatic do_clr();
    @(negedge clk);
    clr = 1;
    idle();
    mptr = 0;
  endtask

  task automatic check_ptr(string req);
    @(negedge clk);
    check(req, int'(ptr0), int'(mptr));
    check(req, int'(ptr1), int'(mptr));
  endtask

  // {write, index, data-or-expected}
  localparam int NV = 14;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 4'd0, 8'h34}, {1'b1, 4'd0, 8'h12},
    {1'b0, 4'd0, 8'h34}, {1'b0, 4'd0, 8'h12},
    {1'b1, 4'd1, 8'h10}, {1'b1, 4'd1, 8'h00},
    {1'b0, 4'd1, 8'h10}, {1'b0, 4'd1, 8'h00},
    {1'b1, 4'd6, 8'hFF}, {1'b1, 4'd6, 8'hFF},
    {1'b0, 4'd6, 8'hFF}, {1'b0, 4'd6, 8'hFF},
    {1'b0, 4'd2, 8'h00}, {1'b0, 4'd3, 8'h00}
  };

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idx = 0; wr = 0; rd = 0; clr = 0; upd = 0; wdata = 0; dec = 0; uch = 0; uval = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    check_ptr("R1 ptr after reset");
    for (int i = 0; i < 8; i++) do_read("R1 zero after reset", i, 0);

    // R5 R6 R7 R8 R9: vector table
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][12]) do_write(int'(VEC[k][11:8]), int'(VEC[k][7:0]));
      else            do_read("R9 table read", int'(VEC[k][11:8]), int'(VEC[k][7:0]));
    end
    check_ptr("R3 ptr after even accesses");

    // R10 R7 R8: progress update
    do_upd(0, 5);
    do_read("R7 count after update", 1); do_read("R7 count after update", 1);
    do_read("R8 addr after update", 0);  do_read("R8 addr after update", 0);
    // R8: count-down address
    dec = 4'b0001;
    do_read("R8 decrement addr", 0); do_read("R8 decrement addr", 0);
    dec = 4'b0000;

    // R3 R4: shared pointer and clear
    do_read("R3 other channel", 2);
    check_ptr("R3 ptr shared toggle");
    do_clr();
    check_ptr("R4 clear alone");
    do_read("R3 toggle again", 2);
    do_read("R4 access with clear uses old ptr", 0, -1, 1'b1);
    check_ptr("R4 clear over toggle");

    // R2: indices 8 and above ignored
    do_write(9, 8'hAA);
    check_ptr("R2 ignored write keeps ptr");
    do_read("R2 ignored read zero", 12, 0);
    check_ptr("R2 ignored read keeps ptr");
    do_read("R2 regs untouched", 0); do_read("R2 regs untouched", 0);

    // R6: low write no reload; count high write reloads address
    do_write(0, 8'h56);
    do_clr();
    do_read("R6 low write keeps current", 0);
    do_write(1, 8'h00);
    do_read("R6 reload from new base", 0); do_read("R6 reload from new base", 0);
    do_read("R6 count cleared", 1); do_read("R6 count cleared", 1);

    // R10: reload beats same-cycle update
    do_write(1, 8'h20);
    do_write(1, 8'h00, 1'b0, 1'b1, 0, 9);
    for (int s = 0; s < 2; s++) mcc[s][0] = 0;
    do_read("R10 reload wins", 1); do_read("R10 reload wins", 1);
    do_upd(3, 16'h0102);
    do_read("R10 update other ch", 6); do_read("R10 update other ch", 6);

    // R1: reset in operation
    do_write(2, 8'h77);
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1 rst_n = 1;
    model_reset();
    check_ptr("R1 ptr after mid reset");
    do_read("R1 cleared", 6); do_read("R1 cleared", 6);
    do_read("R1 cleared", 1); do_read("R1 cleared", 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule